// File: doc/BRIEF.md
# Inverse-Checked I2C Register Slave

This block is an I2C target that lets an external bus master write and read back a small bank of byte-wide registers. Every register access must carry an extra protection byte, which is the bitwise inverse of the register address. The block checks that byte before it touches or returns any register.

SCL and SDA are sampled with a fast system clock through two-flop synchronizers. Bus conditions and clock edges are found by comparing successive synchronized samples. SDA is driven only through an active-high pull-down enable, so the slave never drives the line high.

A write uses a single frame:

`START, addr+W, reg, ~reg, data, STOP`

A read uses a combined frame:

`START, addr+W, reg, ~reg, repeated START, addr+R, data (master NACK), STOP`

The 7-bit device address comes from a parameter. One of its bits is replaced by the level of a strap input. There is no data stream at the block's edge. Configuration bytes leave as plain level outputs, and status bytes enter as plain level inputs.

Top module: `sec_i2c_regs`

## Requirements
- R1: After an asynchronous reset, and whenever the slave is idle, `sda_oe` is 0. Every configuration register takes the value `RST_VAL`, which is 0x00 by default.
- R2: The device address is `DEV_BASE` with bit `ADDR_SEL_BIT` replaced by `addr_sel`. With the defaults this gives 0x6A when `addr_sel` is 0 and 0x6B when it is 1. A first byte whose upper 7 bits do not match is not acknowledged, and `sda_oe` stays 0 until the next START.
- R3: `sda_oe` changes only while the synchronized SCL is low. An acknowledge pulls SDA low before the ninth SCL rise and holds it low through that clock's high phase.
- R4: A write frame whose third byte is the exact inverse of the second byte gets all four bytes acknowledged. The addressed configuration register takes the fourth byte in the same cycle that the fourth acknowledge starts.
- R5: If the third byte is not the inverse of the register address, the slave does not acknowledge it. It then acknowledges nothing further and changes no register until a START or STOP.
- R6: In a combined read after a valid inverse, the read-address byte is acknowledged. The slave then shifts out the register byte MSB first, changing SDA only while SCL is low.
- R7: The configuration registers sit at addresses 0..`NUM_RW`-1. Read-only status entry j sits at address `NUM_RW`+j and reads `status_i[8j+7:8j]`. A write to a status address is acknowledged but changes no register.
- R8: A read from an unimplemented address returns 0x00. A write to one is acknowledged and has no effect.
- R9: A read-address byte that is not preceded, within the same transaction, by a verified inverse byte is not acknowledged. A STOP clears that verification.
- R10: Asserting `rst_n` low in the middle of a frame releases `sda_oe` at once, without waiting for a clock edge, and returns the configuration registers to `RST_VAL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Strap that supplies one device-address bit |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| status_i | input | NUM_RO*8 | Read-only status bytes |
| cfg_o | output | NUM_RW*8 | Configuration register contents, entry i at bits 8i+7:8i |

## Verification
The register write and the start of the acknowledge for the data byte fall on the same system-clock edge. Both are decided at the falling SCL edge that ends the eighth data bit. A checker property requires the pull-down to be asserted in every cycle that carries the write strobe. The bench provokes this overlap with every write frame, both directed and random. It then judges it by two observations: the acknowledge seen at the pin before the ninth SCL rise, and `cfg_o` sampled after the STOP. A second overlap occurs between the acknowledge of the read-address byte and the loading of the transmit shift register. The first data bit must appear on the same SCL falling edge that ends that acknowledge. The bench checks this by comparing every read byte with a model of the register bank.

// File: rtl/sec_i2c_pkg.sv
package sec_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TXACK, ST_IGNORE
  } bus_state_e;

  typedef enum logic [2:0] {
    PH_DEV, PH_REG, PH_INV, PH_DATA, PH_DONE
  } phase_e;
endpackage

// File: rtl/sec_i2c_sync.sv
module sec_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;
  logic [LINES-1:0]  raw;
  logic [STAGES-1:0] chain [LINES];
  logic [LINES-1:0]  synced;
  logic [LINES-1:0]  prev;

  assign raw = {scl_i, sda_i};

  // One synchronizer chain per bus line; the idle bus level is high.
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= '1;
      else        chain[g] <= {chain[g][STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[g][STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= synced;
  end

  assign scl_s     = synced[1];
  assign sda_s     = synced[0];
  assign scl_rise  = scl_s & ~prev[1];
  assign scl_fall  = ~scl_s & prev[1];
  assign start_det = scl_s & prev[1] & prev[0] & ~sda_s;
  assign stop_det  = scl_s & prev[1] & ~prev[0] & sda_s;
endmodule

// File: rtl/sec_i2c_engine.sv
module sec_i2c_engine
  import sec_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] dev_addr,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic [7:0] reg_addr,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       sda_oe,
  output bus_state_e state
);
  phase_e     phase;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic [7:0] tx_q;
  logic       verified;
  logic       ack_to_tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      phase     <= PH_DEV;
      bitcnt    <= '0;
      shreg     <= '0;
      tx_q      <= '0;
      reg_addr  <= '0;
      verified  <= 1'b0;
      ack_to_tx <= 1'b0;
      sda_oe    <= 1'b0;
      wr_en     <= 1'b0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        state    <= ST_IDLE;
        sda_oe   <= 1'b0;
        verified <= 1'b0;
      end else if (start_det) begin
        state  <= ST_RX;
        phase  <= PH_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt    <= '0;
              ack_to_tx <= 1'b0;
              unique case (phase)
                PH_DEV: begin
                  if (shreg[7:1] != dev_addr) begin
                    state <= ST_IDLE;
                  end else if (!shreg[0]) begin
                    state  <= ST_ACK;
                    sda_oe <= 1'b1;
                    phase  <= PH_REG;
                  end else if (verified) begin
                    state     <= ST_ACK;
                    sda_oe    <= 1'b1;
                    ack_to_tx <= 1'b1;
                    tx_q      <= rd_data;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                PH_REG: begin
                  reg_addr <= shreg;
                  verified <= 1'b0;
                  state    <= ST_ACK;
                  sda_oe   <= 1'b1;
                  phase    <= PH_INV;
                end
                PH_INV: begin
                  if (shreg == ~reg_addr) begin
                    verified <= 1'b1;
                    state    <= ST_ACK;
                    sda_oe   <= 1'b1;
                    phase    <= PH_DATA;
                  end else begin
                    verified <= 1'b0;
                    state    <= ST_IGNORE;
                  end
                end
                PH_DATA: begin
                  wr_en   <= 1'b1;
                  wr_data <= shreg;
                  state   <= ST_ACK;
                  sda_oe  <= 1'b1;
                  phase   <= PH_DONE;
                end
                default: state <= ST_IGNORE;
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (ack_to_tx) begin
                state  <= ST_TX;
                sda_oe <= ~tx_q[7];
                tx_q   <= {tx_q[6:0], 1'b0};
              end else begin
                state  <= ST_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                state  <= ST_TXACK;
              end else begin
                sda_oe <= ~tx_q[7];
                tx_q   <= {tx_q[6:0], 1'b0};
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) state <= ST_IGNORE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sec_i2c_regfile.sv
module sec_i2c_regfile #(
  parameter int         NUM_RW  = 4,
  parameter int         NUM_RO  = 2,
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [7:0]          addr,
  input  logic [7:0]          wr_data,
  input  logic [NUM_RO*8-1:0] status_i,
  output logic [7:0]          rd_data,
  output logic [NUM_RW*8-1:0] cfg_o
);
  logic [7:0] cfg_q [NUM_RW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_RW; i++) cfg_q[i] <= RST_VAL;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_RW; i++)
        if (addr == 8'(i)) cfg_q[i] <= wr_data;
    end
  end

  for (genvar g = 0; g < NUM_RW; g++) begin : g_out
    assign cfg_o[8*g +: 8] = cfg_q[g];
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_RW; i++)
      if (addr == 8'(i)) rd_data = cfg_q[i];
    for (int j = 0; j < NUM_RO; j++)
      if (addr == 8'(NUM_RW + j)) rd_data = status_i[8*j +: 8];
  end
endmodule

// File: rtl/sec_i2c_regs.sv
module sec_i2c_regs
  import sec_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_BASE     = 7'h6A,
  parameter int         ADDR_SEL_BIT = 0,
  parameter int         NUM_RW       = 4,
  parameter int         NUM_RO       = 2,
  parameter logic [7:0] RST_VAL      = 8'h00,
  parameter int         SYNC_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                addr_sel,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe,
  input  logic [NUM_RO*8-1:0] status_i,
  output logic [NUM_RW*8-1:0] cfg_o
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [6:0] dev_addr;
  logic [7:0] reg_addr, wr_data, rd_data;
  logic       wr_en;
  bus_state_e bus_state;

  always_comb begin
    dev_addr               = DEV_BASE;
    dev_addr[ADDR_SEL_BIT] = addr_sel;
  end

  sec_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  sec_i2c_engine u_engine (
    .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .rd_data(rd_data), .reg_addr(reg_addr),
    .wr_en(wr_en), .wr_data(wr_data), .sda_oe(sda_oe), .state(bus_state)
  );

  sec_i2c_regfile #(.NUM_RW(NUM_RW), .NUM_RO(NUM_RO), .RST_VAL(RST_VAL)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(reg_addr),
    .wr_data(wr_data), .status_i(status_i), .rd_data(rd_data), .cfg_o(cfg_o)
  );
endmodule

// File: rtl/sec_i2c_regs_chk.sv
module sec_i2c_regs_chk
  import sec_i2c_pkg::*;
#(
  parameter int NUM_RW = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                scl_s,
  input logic                sda_oe,
  input bus_state_e          state,
  input logic                wr_en,
  input logic [7:0]          wr_addr,
  input logic [NUM_RW*8-1:0] cfg_o
);
  // R1: an idle slave never pulls the line
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R3: the pull-down toggles only while SCL is low
  p_oe_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  // R4: a register write coincides with the acknowledge of the data byte
  p_wr_with_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> sda_oe);

  // R5: after a bad inverse byte the slave stays silent
  p_ignore_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> !sda_oe);

  // R7: writes above the configuration range leave every register alone
  p_ro_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= 8'(NUM_RW)) |=> $stable(cfg_o));
endmodule

bind sec_i2c_regs sec_i2c_regs_chk #(.NUM_RW(NUM_RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .state(bus_state), .wr_en(wr_en), .wr_addr(reg_addr), .cfg_o(cfg_o)
);

// File: tb/sec_i2c_regs_test.sv
module sec_i2c_regs_test;
  localparam int NUM_RW = 4;
  localparam int NUM_RO = 2;
  localparam int Q      = 8;
  localparam logic [15:0] STATUS = 16'hC35A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_sel = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NUM_RO*8-1:0] status_i = STATUS;
  logic [NUM_RW*8-1:0] cfg_o;
  logic sda_bus;

  assign sda_bus = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  sec_i2c_regs uut (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_i(scl_m),
    .sda_i(sda_bus), .sda_oe(sda_oe), .status_i(status_i), .cfg_o(cfg_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model [NUM_RW];
  bit mon_en = 1'b0;
  int oe_seen = 0;
  bit last_early;

  always @(posedge clk) if (mon_en && sda_oe) oe_seen++;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] model_flat();
    logic [31:0] f;
    for (int i = 0; i < NUM_RW; i++) f[8*i +: 8] = model[i];
    return f;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] ra);
    if (ra < NUM_RW) return model[ra];
    if (ra < NUM_RW + NUM_RO) return STATUS[8*(ra-NUM_RW) +: 8];
    return 8'h00;
  endfunction

  task automatic bus_start();
    sda_m = 1; scl_m = 1; tick(Q);
    sda_m = 0; tick(Q);
    scl_m = 0; tick(Q);
  endtask

  task automatic bus_restart();
    sda_m = 1; tick(Q);
    scl_m = 1; tick(Q);
    sda_m = 0; tick(Q);
    scl_m = 0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; tick(Q);
    scl_m = 1; tick(Q);
    sda_m = 1; tick(Q);
  endtask

  task automatic put_bit(input bit b);
    sda_m = b; tick(Q);
    scl_m = 1; tick(2*Q);
    scl_m = 0; tick(Q);
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1; tick(Q);
    scl_m = 1; tick(Q);
    b = sda_bus; tick(Q);
    scl_m = 0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    sda_m = 1; tick(Q);
    last_early = (sda_bus == 1'b0);
    scl_m = 1; tick(Q);
    ack = (sda_bus == 1'b0);
    tick(Q);
    scl_m = 0; tick(Q);
  endtask

  task automatic wr_txn(input logic [6:0] dev, input logic [7:0] ra, input logic [7:0] inv,
                        input logic [7:0] d, output bit a0, output bit a1, output bit a2, output bit a3);
    a1 = 0; a2 = 0; a3 = 0;
    bus_start();
    send_byte({dev, 1'b0}, a0);
    if (a0) begin
      send_byte(ra, a1);
      send_byte(inv, a2);
      send_byte(d, a3);
    end
    bus_stop();
  endtask

  task automatic rd_txn(input logic [6:0] dev, input logic [7:0] ra, input logic [7:0] inv,
                        output bit a2, output bit a3, output logic [7:0] d);
    bit a0, a1, b;
    a2 = 0; a3 = 0; d = 8'h00;
    bus_start();
    send_byte({dev, 1'b0}, a0);
    send_byte(ra, a1);
    send_byte(inv, a2);
    bus_restart();
    send_byte({dev, 1'b1}, a3);
    if (a3) begin
      for (int i = 7; i >= 0; i--) begin
        get_bit(b);
        d[i] = b;
      end
      put_bit(1'b1);
    end
    bus_stop();
  endtask

  initial begin
    bit a0, a1, a2, a3;
    logic [7:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < NUM_RW; i++) model[i] = 8'h00;
    tick(5);
    check(sda_oe == 1'b0, "R1 reset oe", 32'(sda_oe), 0);
    check(cfg_o == 32'h0, "R1 reset cfg", cfg_o, 0);
    rst_n = 1; tick(5);

    // R4 directed write with valid inverse
    wr_txn(7'h6A, 8'h02, 8'hFD, 8'hA5, a0, a1, a2, a3);
    check(last_early, "R3 ack before rise", 32'(last_early), 1);
    check({a0, a1, a2, a3} == 4'hF, "R4 write acks", {a0, a1, a2, a3}, 4'hF);
    model[2] = 8'hA5;
    check(cfg_o == model_flat(), "R4 cfg after write", cfg_o, model_flat());

    // R6 readback
    rd_txn(7'h6A, 8'h02, 8'hFD, a2, a3, d);
    check(a3, "R6 read addr ack", 32'(a3), 1);
    check(d == 8'hA5, "R6 read data", d, 8'hA5);

    // R5 bad inverse
    wr_txn(7'h6A, 8'h01, 8'hFF, 8'h3C, a0, a1, a2, a3);
    check(!a2, "R5 bad inverse nack", 32'(a2), 0);
    check(!a3, "R5 data ignored", 32'(a3), 0);
    check(cfg_o == model_flat(), "R5 no change", cfg_o, model_flat());

    // R2 address mismatch and strap
    mon_en = 1; oe_seen = 0;
    wr_txn(7'h6B, 8'h00, 8'hFF, 8'h11, a0, a1, a2, a3);
    mon_en = 0;
    check(!a0, "R2 mismatch nack", 32'(a0), 0);
    check(oe_seen == 0, "R2 no drive on mismatch", oe_seen, 0);
    addr_sel = 1; tick(4);
    wr_txn(7'h6B, 8'h00, 8'hFF, 8'h77, a0, a1, a2, a3);
    check({a0, a3} == 2'b11, "R2 strap address", {a0, a3}, 2'b11);
    model[0] = 8'h77;
    check(cfg_o == model_flat(), "R2 strap write", cfg_o, model_flat());
    addr_sel = 0; tick(4);

    // R7 status write discarded, read returns status
    wr_txn(7'h6A, 8'h04, 8'hFB, 8'hEE, a0, a1, a2, a3);
    check(a3, "R7 status write acked", 32'(a3), 1);
    check(cfg_o == model_flat(), "R7 cfg unchanged", cfg_o, model_flat());
    rd_txn(7'h6A, 8'h05, 8'hFA, a2, a3, d);
    check(d == 8'hC3, "R7 status read", d, 8'hC3);

    // R8 unimplemented addresses
    wr_txn(7'h6A, 8'h07, 8'hF8, 8'h99, a0, a1, a2, a3);
    check(a3, "R8 unimpl write acked", 32'(a3), 1);
    check(cfg_o == model_flat(), "R8 unimpl no effect", cfg_o, model_flat());
    rd_txn(7'h6A, 8'h40, 8'hBF, a2, a3, d);
    check(d == 8'h00, "R8 unimpl read zero", d, 0);

    // R9 direct read without verified inverse
    bus_start();
    send_byte({7'h6A, 1'b1}, a0);
    bus_stop();
    check(!a0, "R9 direct read nack", 32'(a0), 0);

    // random mix
    for (int it = 0; it < 24; it++) begin
      logic [7:0] ra, dv, inv;
      bit corrupt, is_wr;
      ra = 8'($urandom % 10);
      dv = 8'($urandom);
      corrupt = ($urandom % 4) == 0;
      is_wr = $urandom % 2;
      inv = corrupt ? (~ra ^ (8'h01 << ($urandom % 8))) : ~ra;
      if (is_wr) begin
        wr_txn(7'h6A, ra, inv, dv, a0, a1, a2, a3);
        check(a3 == !corrupt, corrupt ? "R5 random write" : "R4 random write", 32'(a3), 32'(!corrupt));
        if (!corrupt && ra < NUM_RW) model[ra] = dv;
        check(cfg_o == model_flat(), "R4 random cfg", cfg_o, model_flat());
      end else begin
        rd_txn(7'h6A, ra, inv, a2, a3, d);
        check(a3 == !corrupt, "R9 random read ack", 32'(a3), 32'(!corrupt));
        if (!corrupt) check(d == exp_rd(ra), "R6 random read", d, exp_rd(ra));
      end
    end

    // R10 async reset in the middle of an acknowledge
    bus_start();
    for (int i = 7; i >= 0; i--) put_bit(i == 0 ? 1'b0 : 1'b0 | (7'h6A >> (i - 1)) & 1'b1);
    tick(2);
    check(sda_oe == 1'b1, "R10 ack in progress", 32'(sda_oe), 1);
    #1 rst_n = 0;
    #1 check(sda_oe == 1'b0, "R10 async release", 32'(sda_oe), 0);
    check(cfg_o == 32'h0, "R10 cfg reset", cfg_o, 0);
    tick(2);
    sda_m = 1; tick(2); scl_m = 1; tick(2);
    rst_n = 1; tick(5);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule